// File: doc/BRIEF.md
# Snoop Control Unit Configuration Register Slave

This block is the software-visible register window of a multicore snoop control unit. It sits on a simple 32-bit request bus with byte-lane strobes and decodes a 256-byte address window. It holds a one-bit enable register and a 32-bit per-core power-state register. It also returns a read-only configuration word that is computed at elaboration time from the number of cores.

A few architecturally defined locations are decoded but not backed by storage. They read as zero and drop writes, as a unit with a single bus master would. Any location the block does not decode also reads as zero and drops writes, and it raises an error pulse. The core-count parameter must lie between 1 and 4. Any other value stops elaboration, so no hardware is built.

Top module: `scu_cfg_regs`

## Requirements
- R1: After a synchronous reset, the enable register and the power-state register are both zero, `bus_rdata` is zero and `bus_err` is low.
- R2: The enable register sits at byte address 0x00 (word index 0). A write with strobe bit 0 set stores `bus_wdata[0]` only. A write with strobe bit 0 clear leaves the register unchanged. A read returns the stored bit in bit 0 and zeros in bits 31:1.
- R3: A read of address 0x04 returns `((2**NUM_CPU - 1) << 4) | (NUM_CPU - 1)`. This is 0x72 for three cores. Writes to 0x04 have no effect and raise no error.
- R4: The power-state register is selected by any byte address 0x08 to 0x0B (word index 2). A write replaces only the bytes whose `bus_be` bit is set, where lane i is bits 8i+7:8i. A read at any of these addresses returns the whole word.
- R5: Addresses 0x0C, 0x40 and 0x44 read as zero. Writes to them change no register and raise no error.
- R6: Any other word in the window, including 0x50 and 0x54, reads as zero and drops writes. It also drives `bus_err` high for exactly the one cycle that follows the access.
- R7: Read data is registered. It appears on `bus_rdata` in the cycle after the accepted request and is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address inside the window |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an unsupported access |

## Verification
A write takes effect at the clock edge that samples it. Read data and the error pulse come out of one register stage, so both are due one edge after the request. The bench drives each request on a falling edge and samples the outputs shortly after the next rising edge. Each expected value is therefore compared in the single cycle where it is due. To confirm that a pulse or read value lasts only one cycle, the bench adds idle cycles and checks that the outputs have returned to zero.

// File: rtl/scu_regs_pkg.sv
package scu_regs_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int WIDX_W = ADDR_W - $clog2(LANES);
    localparam int MAX_CPU = 4;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_CONF,
        SEL_PWR,
        SEL_RAZ,
        SEL_BAD
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } access_t;

    function automatic reg_sel_e decode_word(input logic [WIDX_W-1:0] widx);
        case (widx)
            6'h00:   return SEL_CTRL;
            6'h01:   return SEL_CONF;
            6'h02:   return SEL_PWR;
            6'h03,
            6'h10,
            6'h11:   return SEL_RAZ;
            default: return SEL_BAD;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] conf_word(input int n);
        logic [DATA_W-1:0] mask;
        mask = (DATA_W'(1) << n) - DATA_W'(1);
        return (mask << 4) | DATA_W'(n - 1);
    endfunction

endpackage

// File: rtl/scu_addr_decode.sv
module scu_addr_decode
    import scu_regs_pkg::*;
(
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output access_t           acc
);
    logic unused_lo;
    assign unused_lo = ^addr[$clog2(LANES)-1:0];

    always_comb begin
        acc.rd  = req && !wr;
        acc.wr  = req && wr;
        acc.sel = decode_word(addr[ADDR_W-1:$clog2(LANES)]);
    end
endmodule

// File: rtl/scu_reg_bank.sv
module scu_reg_bank
    import scu_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output logic              ctrl_q,
    output logic [DATA_W-1:0] pwr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= 1'b0;
        end else if (acc.wr && acc.sel == SEL_CTRL && be[0]) begin
            ctrl_q <= wdata[0];
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                pwr_q[8*g +: 8] <= 8'h00;
            end else if (acc.wr && acc.sel == SEL_PWR && be[g]) begin
                pwr_q[8*g +: 8] <= wdata[8*g +: 8];
            end
        end
    end
endmodule

// File: rtl/scu_rd_resp.sv
module scu_rd_resp
    import scu_regs_pkg::*;
#(
    parameter int NUM_CPU = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  logic              ctrl_q,
    input  logic [DATA_W-1:0] pwr_q,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    localparam logic [DATA_W-1:0] CONF = conf_word(NUM_CPU);

    logic [DATA_W-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (acc.rd) begin
            case (acc.sel)
                SEL_CTRL: rd_next = {{(DATA_W-1){1'b0}}, ctrl_q};
                SEL_CONF: rd_next = CONF;
                SEL_PWR:  rd_next = pwr_q;
                default:  rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= rd_next;
            err   <= (acc.rd || acc.wr) && acc.sel == SEL_BAD;
        end
    end
endmodule

// File: rtl/scu_cfg_regs.sv
module scu_cfg_regs
    import scu_regs_pkg::*;
#(
    parameter int NUM_CPU = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_err
);
    if (NUM_CPU < 1 || NUM_CPU > MAX_CPU) begin : g_bad_count
        $error("scu_cfg_regs: NUM_CPU must lie in 1..4");
    end

    access_t     acc;
    logic        ctrl_q;
    logic [31:0] pwr_q;

    scu_addr_decode u_dec (
        .req  (bus_sel),
        .wr   (bus_wr),
        .addr (bus_addr),
        .acc  (acc)
    );

    scu_reg_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .be     (bus_be),
        .wdata  (bus_wdata),
        .ctrl_q (ctrl_q),
        .pwr_q  (pwr_q)
    );

    scu_rd_resp #(.NUM_CPU(NUM_CPU)) u_resp (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .ctrl_q (ctrl_q),
        .pwr_q  (pwr_q),
        .rdata  (bus_rdata),
        .err    (bus_err)
    );
endmodule

// File: rtl/scu_cfg_regs_chk.sv
module scu_cfg_regs_chk
    import scu_regs_pkg::*;
#(
    parameter int NUM_CPU = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [3:0]  bus_be,
    input logic [31:0] bus_rdata,
    input logic        bus_err,
    input logic        ctrl_q,
    input logic [31:0] pwr_q
);
    localparam logic [31:0] CONF = conf_word(NUM_CPU);

    // R1
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (bus_rdata == 32'h0 && !bus_err && !ctrl_q && pwr_q == 32'h0));

    // R2
    p_ctrl_read_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr[7:2] == 6'h00) |=> bus_rdata[31:1] == 31'h0);

    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr && bus_addr[7:2] == 6'h00 && bus_be[0]) |=> $stable(ctrl_q));

    // R3
    p_conf_value_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr[7:2] == 6'h01) |=> bus_rdata == CONF);

    // R4
    p_pwr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr && bus_addr[7:2] == 6'h02) |=> $stable(pwr_q));

    // R6
    p_err_needs_req_r6: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> !bus_err);

    // R7
    p_idle_rdata_r7: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr) |=> bus_rdata == 32'h0);
endmodule

bind scu_cfg_regs scu_cfg_regs_chk #(.NUM_CPU(NUM_CPU)) u_chk (.*);

// File: tb/sim_scu_cfg_regs.sv
`timescale 1ns/1ps
module sim_scu_cfg_regs;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    // encodings: wr=1 write; conf for 3 cores = 0x72
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 4'hF, 32'h0,        32'h0,        1'b0, 8'd2}, // R2 reset value
        '{1'b1, 8'h00, 4'hF, 32'hFFFFFFFF, 32'h0,        1'b0, 8'd2},
        '{1'b0, 8'h00, 4'hF, 32'h0,        32'h1,        1'b0, 8'd2}, // R2 only bit 0
        '{1'b1, 8'h00, 4'hE, 32'h0,        32'h0,        1'b0, 8'd2}, // lane0 off
        '{1'b0, 8'h00, 4'hF, 32'h0,        32'h1,        1'b0, 8'd2},
        '{1'b1, 8'h00, 4'h1, 32'hFFFFFFFE, 32'h0,        1'b0, 8'd2},
        '{1'b0, 8'h00, 4'hF, 32'h0,        32'h0,        1'b0, 8'd2},
        '{1'b0, 8'h04, 4'hF, 32'h0,        32'h72,       1'b0, 8'd3}, // R3
        '{1'b1, 8'h04, 4'hF, 32'h0,        32'h0,        1'b0, 8'd3},
        '{1'b0, 8'h04, 4'hF, 32'h0,        32'h72,       1'b0, 8'd3},
        '{1'b1, 8'h08, 4'hF, 32'h11223344, 32'h0,        1'b0, 8'd4}, // R4
        '{1'b0, 8'h08, 4'hF, 32'h0,        32'h11223344, 1'b0, 8'd4},
        '{1'b1, 8'h0A, 4'h4, 32'hAABBCCDD, 32'h0,        1'b0, 8'd4},
        '{1'b0, 8'h0B, 4'hF, 32'h0,        32'h11BB3344, 1'b0, 8'd4},
        '{1'b1, 8'h09, 4'h9, 32'h55000066, 32'h0,        1'b0, 8'd4},
        '{1'b0, 8'h08, 4'hF, 32'h0,        32'h55BB3366, 1'b0, 8'd4},
        '{1'b1, 8'h0C, 4'hF, 32'hFFFFFFFF, 32'h0,        1'b0, 8'd5}, // R5
        '{1'b0, 8'h0C, 4'hF, 32'h0,        32'h0,        1'b0, 8'd5},
        '{1'b1, 8'h40, 4'hF, 32'h00001234, 32'h0,        1'b0, 8'd5},
        '{1'b0, 8'h40, 4'hF, 32'h0,        32'h0,        1'b0, 8'd5},
        '{1'b0, 8'h44, 4'hF, 32'h0,        32'h0,        1'b0, 8'd5},
        '{1'b1, 8'h50, 4'hF, 32'hFFFFFFFF, 32'h0,        1'b1, 8'd6}, // R6
        '{1'b0, 8'h54, 4'hF, 32'h0,        32'h0,        1'b1, 8'd6},
        '{1'b0, 8'hFC, 4'hF, 32'h0,        32'h0,        1'b1, 8'd6},
        '{1'b1, 8'h10, 4'hF, 32'hFFFFFFFF, 32'h0,        1'b1, 8'd6},
        '{1'b0, 8'h08, 4'hF, 32'h0,        32'h55BB3366, 1'b0, 8'd6},
        '{1'b0, 8'h00, 4'hF, 32'h0,        32'h0,        1'b0, 8'd6},
        '{1'b0, 8'h04, 4'hF, 32'h0,        32'h72,       1'b0, 8'd7}  // R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    scu_cfg_regs #(.NUM_CPU(3)) u0 (.*);

    task automatic check(input string tag, input logic [31:0] act_rd, input logic act_err,
                         input logic [31:0] exp_rd, input logic exp_err);
        n_chk++;
        if (act_rd !== exp_rd || act_err !== exp_err) begin
            n_bad++;
            $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                     tag, act_rd, act_err, exp_rd, exp_err);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] a, input logic [3:0] be,
                          input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk);
        #1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic idle_check(input string tag);
        @(posedge clk);
        #1;
        check(tag, bus_rdata, bus_err, 32'h0, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", bus_rdata, bus_err, 32'h0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        foreach (VEC[i]) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = VEC[i].wr; bus_addr = VEC[i].addr;
            bus_be = VEC[i].be; bus_wdata = VEC[i].wdata;
            @(posedge clk);
            #1;
            bus_sel = 1'b0;
            check($sformatf("R%0d vector %0d", VEC[i].req, i), bus_rdata, bus_err,
                  VEC[i].exp_rd, VEC[i].exp_err);
        end

        // R6: pulse lasts one cycle; R7: idle returns zero
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h80; bus_be = 4'hF;
        @(posedge clk);
        #1;
        check("R6 bad read pulse", bus_rdata, bus_err, 32'h0, 1'b1);
        bus_sel = 1'b0;
        idle_check("R6 pulse ends / R7 idle zero");

        // R7: read followed by idle
        access(1'b0, 8'h08, 4'hF, 32'h0);
        idle_check("R7 data one cycle only");

        // R5 write to 0x44 leaves the power word
        access(1'b1, 8'h44, 4'hF, 32'hDEADBEEF);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h08;
        @(posedge clk);
        #1;
        check("R5 0x44 write ignored", bus_rdata, bus_err, 32'h55BB3366, 1'b0);

        // R1: reset mid-run clears state
        access(1'b1, 8'h00, 4'h1, 32'h1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 outputs in reset", bus_rdata, bus_err, 32'h0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h00;
        @(posedge clk);
        #1;
        check("R1 enable cleared", bus_rdata, bus_err, 32'h0, 1'b0);
        @(negedge clk);
        bus_addr = 8'h0A;
        @(posedge clk);
        #1;
        check("R1 power cleared", bus_rdata, bus_err, 32'h0, 1'b0);
        bus_sel = 1'b0;

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule